// File: doc/BRIEF.md
# Fractional Baud Pulse Thinner

This block trims the rate of a stream of clock-enable pulses before they reach a baud-rate divider. Software picks a share N (0 to 255) of every 256 input pulses. While modulation is active, exactly N pulses of each 256-pulse window go through, spread as evenly as a phase accumulator allows. The average base-clock period therefore grows by 256/N, and the bit rate falls by N/256. The thinned stream then drives a reload-down divider that makes the base-clock tick, and a modulo-16 counter turns base ticks into one bit tick per bit period.

A single write strobe loads the enable, the share and the divider reload at the same time, and restarts every counter. A `sync_mode` input forces pass-through for the operating modes in which modulation must not be used: clock-synchronous transfer and the fastest SPI setting.

A two-state controller picks the path. In `ST_BYPASS`, every pulse passes and the accumulator stays at zero. In `ST_MODULATE`, pulses are thinned. Transition `T_ENGAGE` goes from `ST_BYPASS` to `ST_MODULATE` when the stored enable is 1 and `sync_mode` is 0. Transition `T_RELEASE` goes back when either condition fails. During a write cycle, the next state is computed from the enable value being written. Otherwise the state follows `sync_mode` one cycle later.

Top module: `frac_baud_gate`

## Requirements
- R1: While `rst_n` is low, `pass_pulse`, `base_tick` and `bit_tick` are 0.
- R2: With modulation active and share N, starting from a write, every run of 256 input pulses yields exactly N pulses on `pass_pulse`.
- R3: With modulation active and N>0, counting from a write or from the previous passed pulse, no passed pulse needs more than ceil(256/N) input pulses.
- R4: With the enable 0, every input pulse appears on `pass_pulse`.
- R5: With `sync_mode` 1, the block passes every pulse even when the enable is 1. The forced bypass applies from the cycle after `sync_mode` rises.
- R6: With modulation active and N=0, no pulse passes.
- R7: With reload value D, `base_tick` fires once per D+1 passed pulses. The first tick after a write comes on the (D+1)-th passed pulse.
- R8: `bit_tick` fires once per 16 `base_tick` pulses. The first comes on the 16th base tick after a write.
- R9: A `cfg_wr` cycle clears the accumulator, loads the divider with the new reload, clears the bit counter and drops any pulse in flight. An input pulse in that same cycle is ignored, and all three outputs are 0 in the following cycle.
- R10: `pass_pulse` rises one cycle after the input pulse that is passed. `base_tick` rises one cycle after the passed pulse that ends a divider count. `bit_tick` rises one cycle after the base tick that ends a bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_in | input | 1 | Internal clock-enable pulse feeding the thinner |
| sync_mode | input | 1 | 1 = synchronous or fastest-SPI operation; forces pass-through |
| cfg_wr | input | 1 | Write strobe: loads the three configuration values and restarts all counters |
| cfg_mod_en | input | 1 | Modulation enable, loaded on `cfg_wr` |
| cfg_mod_value | input | 8 | Share N of passed pulses per 256, loaded on `cfg_wr` |
| cfg_reload | input | 8 | Divider reload D, loaded on `cfg_wr` |
| pass_pulse | output | 1 | Thinned pulse stream |
| base_tick | output | 1 | Base-clock tick, one per D+1 passed pulses |
| bit_tick | output | 1 | Bit-period tick, one per 16 base ticks |

## Verification
The hardest condition to reach is a write that lands while the counters hold partial state. A missing clear is visible at the ports only when the leftover accumulator phase or divider count would change a later total. The stimulus therefore runs 100 pulses at N=160 with a divide-by-7 divider, leaving the divider one pulse short of a tick. It then writes the same values again, so a stale count would add a 23rd base tick where 22 are expected. A single-pulse run shows the accumulator clear: 160 held over a write would carry on the next pulse. A 10-then-8 base-tick run shows the bit-counter clear.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
    typedef enum logic [0:0] {
        ST_BYPASS   = 1'b0,
        ST_MODULATE = 1'b1
    } gate_state_t;
endpackage

// File: rtl/frac_baud_thin.sv
module frac_baud_thin #(
    parameter int ACC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             pulse_in,
    input  logic             modulate,
    input  logic [ACC_W-1:0] share,
    output logic             pass_o
);
    logic [ACC_W-1:0] phase_q;
    logic [ACC_W:0]   phase_sum;

    // Carry out of the top bit marks a pulse to pass.
    assign phase_sum = {1'b0, phase_q} + {1'b0, share};

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase_q <= '0;
            pass_o  <= 1'b0;
        end else begin
            pass_o <= 1'b0;
            if (!modulate) begin
                phase_q <= '0;
                if (pulse_in) pass_o <= 1'b1;
            end else if (pulse_in) begin
                phase_q <= phase_sum[ACC_W-1:0];
                pass_o  <= phase_sum[ACC_W];
            end
        end
    end

    assert_pass_follows_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> $past(pulse_in));
    assert_bypass_passes_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_in && !modulate && !clr) |=> pass_o);
    assert_bypass_phase_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !modulate |=> (phase_q == '0));
    assert_zero_share_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (modulate && share == '0 && !clr) |=> !pass_o);
endmodule

// File: rtl/frac_baud_div.sv
module frac_baud_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             pass_in,
    input  logic [DIV_W-1:0] reload,
    output logic             base_o
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            base_o <= 1'b0;
        end else if (clr) begin
            cnt_q  <= reload;
            base_o <= 1'b0;
        end else begin
            base_o <= 1'b0;
            if (pass_in) begin
                if (cnt_q == '0) begin
                    base_o <= 1'b1;
                    cnt_q  <= reload;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assert_base_needs_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        base_o |-> $past(pass_in));
    assert_no_early_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_in && !clr && cnt_q != '0) |=> !base_o);
endmodule

// File: rtl/frac_baud_bitcnt.sv
module frac_baud_bitcnt #(
    parameter int BASE_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic base_in,
    output logic bit_o
);
    localparam int CNT_W = (BASE_PER_BIT > 1) ? $clog2(BASE_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BASE_PER_BIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            bit_o <= 1'b0;
        end else begin
            bit_o <= 1'b0;
            if (base_in) begin
                if (cnt_q == LAST) begin
                    cnt_q <= '0;
                    bit_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assert_bit_needs_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_o |-> $past(base_in));
endmodule

// File: rtl/frac_baud_gate.sv
module frac_baud_gate #(
    parameter int ACC_W        = 8,
    parameter int DIV_W        = 8,
    parameter int BASE_PER_BIT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic             sync_mode,
    input  logic             cfg_wr,
    input  logic             cfg_mod_en,
    input  logic [ACC_W-1:0] cfg_mod_value,
    input  logic [DIV_W-1:0] cfg_reload,
    output logic             pass_pulse,
    output logic             base_tick,
    output logic             bit_tick
);
    import frac_baud_pkg::*;

    gate_state_t      state_q, state_d;
    logic             en_q;
    logic [ACC_W-1:0] share_q;
    logic [DIV_W-1:0] reload_q;
    logic [DIV_W-1:0] reload_eff;
    logic             en_eff;
    logic             modulate;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            share_q  <= '0;
            reload_q <= '0;
        end else if (cfg_wr) begin
            en_q     <= cfg_mod_en;
            share_q  <= cfg_mod_value;
            reload_q <= cfg_reload;
        end
    end

    assign en_eff     = cfg_wr ? cfg_mod_en : en_q;
    assign reload_eff = cfg_wr ? cfg_reload : reload_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BYPASS;
        else        state_q <= state_d;
    end

    // Next state: T_ENGAGE / T_RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BYPASS:   if (en_eff && !sync_mode)  state_d = ST_MODULATE;
            ST_MODULATE: if (!en_eff || sync_mode) state_d = ST_BYPASS;
            default:     state_d = ST_BYPASS;
        endcase
    end

    // Outputs of the controller
    always_comb begin
        unique case (state_q)
            ST_MODULATE: modulate = 1'b1;
            default:     modulate = 1'b0;
        endcase
    end

    logic pass_w, base_w, bit_w;

    frac_baud_thin #(.ACC_W(ACC_W)) u_thin (
        .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .pulse_in(pulse_in),
        .modulate(modulate), .share(share_q), .pass_o(pass_w)
    );

    frac_baud_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .pass_in(pass_w),
        .reload(reload_eff), .base_o(base_w)
    );

    frac_baud_bitcnt #(.BASE_PER_BIT(BASE_PER_BIT)) u_bits (
        .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .base_in(base_w), .bit_o(bit_w)
    );

    assign pass_pulse = pass_w;
    assign base_tick  = base_w;
    assign bit_tick   = bit_w;

    assert_sync_forces_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_mode |=> !modulate);
    assert_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (!pass_pulse && !base_tick && !bit_tick));
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!pass_pulse && !base_tick && !bit_tick));
endmodule

// File: tb/frac_baud_gate_bench.sv
module frac_baud_gate_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pulse_in = 1'b0, sync_mode = 1'b0, cfg_wr = 1'b0, cfg_mod_en = 1'b0;
    logic [7:0] cfg_mod_value = '0, cfg_reload = '0;
    logic pass_pulse, base_tick, bit_tick;

    always #5 clk = ~clk;

    frac_baud_gate u_frac_baud_gate (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .sync_mode(sync_mode),
        .cfg_wr(cfg_wr), .cfg_mod_en(cfg_mod_en), .cfg_mod_value(cfg_mod_value),
        .cfg_reload(cfg_reload), .pass_pulse(pass_pulse), .base_tick(base_tick),
        .bit_tick(bit_tick)
    );

    typedef struct {
        string tag;
        int    n_pass;
        int    n_base;
        int    n_bit;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0, fails = 0;
    int cnt_pass = 0, cnt_base = 0, cnt_bit = 0;
    int gap = 0, gap_lim = 0;
    bit done = 1'b0;

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Monitor and scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (cfg_wr) gap = 0;
            if (pass_pulse) begin
                if (gap_lim > 0)
                    check(gap <= gap_lim, "R3", "input pulses per passed pulse", gap, gap_lim);
                gap = 0;
            end
            if (pulse_in && !cfg_wr) gap++;
            cnt_pass += int'(pass_pulse);
            cnt_base += int'(base_tick);
            cnt_bit  += int'(bit_tick);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(cnt_pass == e.n_pass, e.tag, "passed pulses", cnt_pass, e.n_pass);
                check(cnt_base == e.n_base, "R7", {e.tag, " base ticks"}, cnt_base, e.n_base);
                check(cnt_bit == e.n_bit, "R8", {e.tag, " bit ticks"}, cnt_bit, e.n_bit);
                cnt_pass = 0; cnt_base = 0; cnt_bit = 0;
            end
        end
    end

    task automatic configure(bit en, int n, int r, bit with_pulse);
        @(posedge clk); #2;
        cfg_mod_en = en; cfg_mod_value = 8'(n); cfg_reload = 8'(r);
        cfg_wr = 1'b1; pulse_in = with_pulse;
        gap_lim = (en && !sync_mode && n > 0) ? (256 + n - 1) / n : 0;
        @(posedge clk); #2;
        cfg_wr = 1'b0; pulse_in = 1'b0;
    endtask

    task automatic burst(int n, bit gapped);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2 pulse_in = 1'b1;
            if (gapped && (i % 3 == 2)) begin
                @(posedge clk); #2 pulse_in = 1'b0;
            end
        end
        @(posedge clk); #2 pulse_in = 1'b0;
    endtask

    task automatic expect_counts(string tag, int p, int b, int t);
        exp_t e;
        repeat (6) @(posedge clk);
        e.tag = tag; e.n_pass = p; e.n_base = b; e.n_bit = t;
        exp_q.push_back(e);
        repeat (2) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!pass_pulse && !base_tick && !bit_tick, "R1", "outputs in reset",
              int'({pass_pulse, base_tick, bit_tick}), 0);
        @(posedge clk); #2 rst_n = 1'b1;

        // R2 R7 R8: N=160, divide by 1, two windows
        configure(1'b1, 160, 0, 1'b0);
        burst(512, 1'b0);
        expect_counts("R2", 320, 320, 20);

        // R2 R3: N=1 worst spacing
        configure(1'b1, 1, 0, 1'b0);
        burst(256, 1'b0);
        expect_counts("R2", 1, 1, 0);

        // R2 R7: N=255, divide by 4, gapped input
        configure(1'b1, 255, 3, 1'b0);
        burst(768, 1'b1);
        expect_counts("R2", 765, 191, 11);

        // R6: N=0 blocks everything
        configure(1'b1, 0, 0, 1'b0);
        burst(256, 1'b0);
        expect_counts("R6", 0, 0, 0);

        // R4: disabled passes all
        configure(1'b0, 200, 0, 1'b0);
        burst(300, 1'b1);
        expect_counts("R4", 300, 300, 18);

        // R5: sync mode forces bypass
        @(posedge clk); #2 sync_mode = 1'b1;
        configure(1'b1, 64, 1, 1'b0);
        burst(256, 1'b0);
        expect_counts("R5", 256, 128, 8);
        @(posedge clk); #2 sync_mode = 1'b0;

        // R9: divider cleared by rewrite (stale count would give 23 ticks)
        configure(1'b1, 160, 6, 1'b0);
        burst(100, 1'b0);
        expect_counts("R9", 62, 8, 0);
        configure(1'b1, 160, 6, 1'b0);
        burst(256, 1'b0);
        expect_counts("R9", 160, 22, 1);

        // R9: accumulator cleared (stale 160 would carry)
        configure(1'b1, 160, 0, 1'b0);
        burst(1, 1'b0);
        configure(1'b1, 160, 0, 1'b0);
        burst(1, 1'b0);
        expect_counts("R9", 0, 0, 0);

        // R9: bit counter cleared
        configure(1'b0, 0, 0, 1'b0);
        burst(10, 1'b0);
        expect_counts("R9", 10, 10, 0);
        configure(1'b0, 0, 0, 1'b0);
        burst(8, 1'b0);
        expect_counts("R9", 8, 8, 0);

        // R9: pulse during write cycle ignored
        configure(1'b0, 0, 0, 1'b1);
        expect_counts("R9", 0, 0, 0);

        // R10: latency of each stage
        configure(1'b0, 0, 0, 1'b0);
        @(posedge clk); #2 pulse_in = 1'b1;
        @(posedge clk); #2 pulse_in = 1'b0;
        @(negedge clk);
        check(pass_pulse && !base_tick, "R10", "pass one cycle after pulse",
              int'({pass_pulse, base_tick}), 2);
        @(negedge clk);
        check(!pass_pulse && base_tick, "R10", "base one cycle after pass",
              int'({pass_pulse, base_tick}), 1);
        expect_counts("R10", 1, 1, 0);

        wait (exp_q.size() == 0);
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule